// File: doc/BRIEF.md
# Chained Result-Block Output Sequencer

This block is the output side of one transform engine in a group of engines that share a single result bus. When its engine signals that a transform has finished, the sequencer reads the finished block out of a local synchronous buffer and presents it one word per output strobe. The strobe is a single-cycle enable in the system clock domain. The sequencer raises a data-available flag and a bus-drive enable while it owns the bus. It also raises an end-of-block marker once the block has been sent.

Several sequencers can be chained. Each one's `chain_en` input is fed by the inverted `dav` of the engine ahead of it, so at most one engine drives the bus at any time. In chained mode the first word is still fetched into the final output register while the engine waits for its turn. When the engine ahead releases the bus, this engine takes it over one clock later, and the two blocks follow each other with no lost strobe slot. In single-engine mode, `chain_en` is ignored.

Output strobes must be at least two clock cycles apart. A finished block has to be written into the buffer before `done` is pulsed.

Top module: `xform_out_seq`

## Requirements
- R1: During reset and after it is released, `dav`, `bus_oe` and `eob_mark` are 0.
- R2: The first strobe after a `done` pulse primes the output. From the next cycle on, `bus_data` holds buffer word 0, and `dav` is still 0 in that cycle.
- R3: With `mode` = 2'b00 (single engine), `dav` rises in the cycle after the priming strobe, whatever the level of `chain_en`.
- R4: With a nonzero `mode` (chained; 2'b01 is the concurrent chained setting) and `chain_en` high at priming, `dav` rises in the cycle after the priming strobe.
- R5: In a chained mode, a primed engine whose `chain_en` is low keeps `dav` low. `dav` rises exactly one clock after `chain_en` is sampled high.
- R6: While primed and held, `bus_oe` stays 0, further strobes do not advance the output, and `bus_data` keeps word 0.
- R7: `bus_oe` equals `dav` in every cycle.
- R8: While `dav` is high, each strobe moves `bus_data` to the next buffer word in address order. `dav` falls on the strobe that closes the last of the BLOCK_LEN words.
- R9: `eob_mark` rises in the cycle after `dav` falls and clears on the next strobe.
- R10: A `done` pulse that arrives while a block is in progress is ignored. No second block is primed or sent.
- R11: Two engines chained through an inverted `dav` never enable the bus together, and their blocks reach the bus back to back with no empty strobe slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Engine-group mode: 00 single engine, nonzero chained (01 concurrent) |
| done | input | 1 | One-cycle pulse: result block is complete in the buffer |
| wr_en | input | 1 | Buffer write enable from the transform side |
| wr_addr | input | ADDR_W | Buffer write address |
| wr_data | input | DATA_W | Buffer write data |
| strobe | input | 1 | Output strobe, single-cycle enable |
| chain_en | input | 1 | Bus permission from the previous engine (active high) |
| dav | output | 1 | Data available: this engine owns the bus |
| bus_oe | output | 1 | Drive enable for the shared result bus |
| bus_data | output | DATA_W | Current output word (final output register) |
| eob_mark | output | 1 | End-of-block marker |

## Verification
The bench targets the held state. It sends extra strobes while `chain_en` is low and checks that word 0 is still on the output and the bus is still released. A design that advanced its address, or one that did not prime ahead of time, would lose or shift words here. It measures the exact cycle `dav` rises in single mode with `chain_en` low, and in chained mode with `chain_en` high and low. A design that mixed up the two modes would either grab the bus early or stall. It pulses `done` mid-block to catch a sequencer that would restart. Finally, it chains two engines and counts bus overlaps and empty strobe slots: an off-by-one hand-over shows up as one or the other.

// File: rtl/xos_pkg.sv
package xos_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PRIME  = 2'd1,
    ST_PRIMED = 2'd2,
    ST_SEND   = 2'd3
  } xos_state_t;

  localparam logic [1:0] MODE_SINGLE = 2'b00;
  localparam logic [1:0] MODE_CONCUR = 2'b01;

  // Any nonzero group mode hands bus ownership along the chain.
  function automatic logic is_chained(input logic [1:0] m);
    return m != MODE_SINGLE;
  endfunction

endpackage

// File: rtl/xos_buf.sv
// Result buffer: one write port, registered read port (block-RAM style).
module xos_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/xos_ctrl.sv
// Output sequencing: priming, hold for chain permission, word stepping.
module xos_ctrl
  import xos_pkg::*;
#(
  parameter int BLOCK_LEN = 64,
  localparam int AW       = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chained,
  input  logic          done,
  input  logic          strobe,
  input  logic          chain_en,
  output xos_state_t    state,
  output logic [AW-1:0] rd_addr,
  output logic          latch_en,
  output logic          own_set,
  output logic          own_clr,
  output logic          dav
);

  localparam logic [AW-1:0] LAST_IDX = AW'(BLOCK_LEN - 1);

  logic [AW-1:0] word_idx;
  logic [AW-1:0] rd_addr_inc;
  logic          at_last;

  assign rd_addr_inc = (rd_addr == LAST_IDX) ? '0 : rd_addr + 1'b1;
  assign at_last     = (word_idx == LAST_IDX);

  // Combinational handshakes derived from the present state.
  always_comb begin
    own_set  = 1'b0;
    own_clr  = 1'b0;
    latch_en = 1'b0;
    unique case (state)
      ST_PRIME:  latch_en = strobe;
      ST_PRIMED: own_set  = !chained || chain_en;
      ST_SEND: begin
        latch_en = strobe && !at_last;
        own_clr  = strobe && at_last;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rd_addr  <= '0;
      word_idx <= '0;
      dav      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (done) begin
            state   <= ST_PRIME;
            rd_addr <= '0;
          end
        end
        ST_PRIME: begin
          if (strobe) begin
            state   <= ST_PRIMED;
            rd_addr <= rd_addr_inc;
          end
        end
        ST_PRIMED: begin
          if (own_set) begin
            state    <= ST_SEND;
            dav      <= 1'b1;
            word_idx <= '0;
          end
        end
        ST_SEND: begin
          if (own_clr) begin
            state   <= ST_IDLE;
            dav     <= 1'b0;
            rd_addr <= '0;
          end else if (strobe) begin
            word_idx <= word_idx + 1'b1;
            rd_addr  <= rd_addr_inc;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xos_eob.sv
// End-of-block marker: set after ownership ends, cleared by a strobe.
module xos_eob (
  input  logic clk,
  input  logic rst,
  input  logic dav,
  input  logic strobe,
  output logic eob
);

  logic dav_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dav_q <= 1'b0;
      eob   <= 1'b0;
    end else begin
      dav_q <= dav;
      if (dav_q && !dav) begin
        eob <= 1'b1;
      end else if (strobe) begin
        eob <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/xform_out_seq.sv
module xform_out_seq
  import xos_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BLOCK_LEN = 64,
  localparam int ADDR_W   = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              done,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              strobe,
  input  logic              chain_en,
  output logic              dav,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_data,
  output logic              eob_mark
);

  xos_state_t        st_w;
  logic [ADDR_W-1:0] rd_addr_w;
  logic [DATA_W-1:0] rd_data_w;
  logic              latch_en_w;
  logic              own_set_w;
  logic              own_clr_w;
  logic              chained_w;
  logic [DATA_W-1:0] out_q;
  logic              oe_q;

  assign chained_w = is_chained(mode);

  xos_buf #(
    .DATA_W (DATA_W),
    .DEPTH  (BLOCK_LEN)
  ) u_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr_w),
    .rd_data (rd_data_w)
  );

  xos_ctrl #(
    .BLOCK_LEN (BLOCK_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .chained  (chained_w),
    .done     (done),
    .strobe   (strobe),
    .chain_en (chain_en),
    .state    (st_w),
    .rd_addr  (rd_addr_w),
    .latch_en (latch_en_w),
    .own_set  (own_set_w),
    .own_clr  (own_clr_w),
    .dav      (dav)
  );

  xos_eob u_eob (
    .clk    (clk),
    .rst    (rst),
    .dav    (dav),
    .strobe (strobe),
    .eob    (eob_mark)
  );

  // Final output register and bus-drive flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      if (latch_en_w) begin
        out_q <= rd_data_w;
      end
      if (own_set_w) begin
        oe_q <= 1'b1;
      end else if (own_clr_w) begin
        oe_q <= 1'b0;
      end
    end
  end

  assign bus_data = out_q;
  assign bus_oe   = oe_q;

endmodule

// File: rtl/xos_chk.sv
module xos_chk
  import xos_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic              strobe,
  input logic              chain_en,
  input logic              dav,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_data,
  input logic              eob_mark,
  input xos_state_t        state
);

  p_oe_follows_dav_r7: assert property (@(posedge clk) disable iff (rst)
    bus_oe == dav);

  p_rise_needs_permission_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(dav) && $past(mode) != MODE_SINGLE) |-> $past(chain_en));

  p_rise_from_primed_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(dav) |-> $past(state) == ST_PRIMED);

  p_held_output_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRIMED && $past(state) == ST_PRIMED) |-> ($stable(bus_data) && !bus_oe));

  p_marker_set_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(dav) |=> eob_mark);

  p_marker_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (eob_mark && strobe && !$fell(dav)) |=> !eob_mark);

endmodule

bind xform_out_seq xos_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .strobe   (strobe),
  .chain_en (chain_en),
  .dav      (dav),
  .bus_oe   (bus_oe),
  .bus_data (bus_data),
  .eob_mark (eob_mark),
  .state    (st_w)
);

// File: tb/xform_out_seq_tb_top.sv
module xform_out_seq_tb_top;

  localparam int DW  = 16;
  localparam int BLK = 8;
  localparam int AW  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [1:0]    mode = 2'b01;
  logic          done_a = 1'b0, done_b = 1'b0;
  logic          wr_en_a = 1'b0, wr_en_b = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          strobe_man = 1'b0;
  logic          strobe_auto = 1'b0;
  logic          auto_on = 1'b0;
  logic          en_a = 1'b0;
  logic          strobe;
  logic          en_b;
  logic          dav_a, oe_a, eob_a, dav_b, oe_b, eob_b;
  logic [DW-1:0] data_a, data_b;

  assign strobe = strobe_man | strobe_auto;
  assign en_b   = ~dav_a;

  xform_out_seq #(.DATA_W(DW), .BLOCK_LEN(BLK)) dut_i (
    .clk(clk), .rst(rst), .mode(mode), .done(done_a), .wr_en(wr_en_a),
    .wr_addr(wr_addr), .wr_data(wr_data), .strobe(strobe), .chain_en(en_a),
    .dav(dav_a), .bus_oe(oe_a), .bus_data(data_a), .eob_mark(eob_a));

  xform_out_seq #(.DATA_W(DW), .BLOCK_LEN(BLK)) dut_b_i (
    .clk(clk), .rst(rst), .mode(mode), .done(done_b), .wr_en(wr_en_b),
    .wr_addr(wr_addr), .wr_data(wr_data), .strobe(strobe), .chain_en(en_b),
    .dav(dav_b), .bus_oe(oe_b), .bus_data(data_b), .eob_mark(eob_b));

  int checks = 0;
  int failures = 0;
  int overlaps = 0;
  int gaps = 0;
  int oe_mismatch = 0;
  bit started = 1'b0;
  logic [DW-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Driver side of the scoreboard: expected words of one block.
  task automatic push_block(input logic [DW-1:0] base);
    for (int i = 0; i < BLK; i++) exp_q.push_back(base + DW'(i));
  endtask

  task automatic load(input bit to_b, input logic [DW-1:0] base);
    for (int i = 0; i < BLK; i++) begin
      @(negedge clk);
      wr_addr = AW'(i);
      wr_data = base + DW'(i);
      wr_en_a = !to_b;
      wr_en_b = to_b;
    end
    @(negedge clk);
    wr_en_a = 1'b0;
    wr_en_b = 1'b0;
  endtask

  task automatic pulse_done(input bit to_b);
    @(negedge clk);
    if (to_b) done_b = 1'b1; else done_a = 1'b1;
    @(negedge clk);
    done_a = 1'b0;
    done_b = 1'b0;
  endtask

  // Raises the strobe for one cycle; returns at the negedge after the edge that used it.
  task automatic pulse_strobe();
    @(negedge clk);
    strobe_man = 1'b1;
    @(negedge clk);
    strobe_man = 1'b0;
  endtask

  // Free-running strobe, one every three cycles.
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (auto_on) begin
        strobe_auto = (cnt == 0);
        cnt = (cnt == 2) ? 0 : cnt + 1;
      end else begin
        strobe_auto = 1'b0;
        cnt = 0;
      end
    end
  end

  // Monitor: sample what the next capturing edge sees on the shared bus.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (!rst) begin
        if (oe_a != dav_a || oe_b != dav_b) oe_mismatch++;
        if (oe_a && oe_b) overlaps++;
        if (strobe) begin
          if (oe_a || oe_b) begin
            logic [DW-1:0] got;
            got = oe_a ? data_a : data_b;
            if (exp_q.size() == 0) begin
              chk(1'b0, "R8 unexpected word", 32'(got), 32'hFFFF);
            end else begin
              logic [DW-1:0] want;
              want = exp_q.pop_front();
              chk(got == want, "R8 word order", 32'(got), 32'(want));
              started = (exp_q.size() != 0);
            end
          end else if (started && exp_q.size() != 0) begin
            gaps++;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!dav_a && !oe_a && !eob_a, "R1 in reset", {dav_a, oe_a, eob_a}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!dav_a && !oe_a && !eob_a && !dav_b, "R1 after reset", {dav_a, oe_a, eob_a, dav_b}, 0);

    load(1'b0, 16'hA000);
    load(1'b1, 16'hB000);

    // Chained mode, permission withheld: prime and hold.
    mode = 2'b01;
    en_a = 1'b0;
    pulse_done(1'b0);
    pulse_strobe();
    chk(data_a == 16'hA000, "R2 first word primed", 32'(data_a), 32'hA000);
    chk(!dav_a, "R2 dav low right after priming", 32'(dav_a), 0);
    @(negedge clk);
    pulse_strobe();
    @(negedge clk);
    pulse_strobe();
    @(negedge clk);
    chk(data_a == 16'hA000 && !oe_a, "R6 held output frozen", {oe_a, data_a}, 32'hA000);
    chk(!dav_a, "R5 no dav without permission", 32'(dav_a), 0);
    push_block(16'hA000);
    en_a = 1'b1;
    @(negedge clk);
    chk(dav_a, "R5 dav one clock after permission", 32'(dav_a), 1);
    auto_on = 1'b1;
    while (dav_a) @(negedge clk);
    chk(exp_q.size() == 0, "R8 dav falls after last word", exp_q.size(), 0);
    @(negedge clk);
    chk(eob_a, "R9 marker set after dav falls", 32'(eob_a), 1);
    @(posedge clk iff strobe);
    @(negedge clk);
    chk(!eob_a, "R9 marker cleared by strobe", 32'(eob_a), 0);
    auto_on = 1'b0;
    repeat (3) @(negedge clk);

    // Single-engine mode: permission ignored.
    mode = 2'b00;
    en_a = 1'b0;
    push_block(16'hA000);
    pulse_done(1'b0);
    pulse_strobe();
    chk(!dav_a && data_a == 16'hA000, "R2 single-mode priming", {dav_a, data_a}, 32'hA000);
    @(negedge clk);
    chk(dav_a, "R3 single mode ignores chain_en", 32'(dav_a), 1);
    auto_on = 1'b1;
    while (dav_a) @(negedge clk);
    auto_on = 1'b0;
    chk(exp_q.size() == 0, "R8 single-mode block complete", exp_q.size(), 0);
    repeat (3) @(negedge clk);

    // Chained mode with permission already present; mid-block done ignored.
    mode = 2'b01;
    en_a = 1'b1;
    push_block(16'hA000);
    pulse_done(1'b0);
    pulse_strobe();
    chk(!dav_a, "R4 dav low in priming cycle", 32'(dav_a), 0);
    @(negedge clk);
    chk(dav_a, "R4 dav rises after priming", 32'(dav_a), 1);
    auto_on = 1'b1;
    repeat (5) @(negedge clk);
    pulse_done(1'b0);
    while (dav_a) @(negedge clk);
    auto_on = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      pulse_strobe();
      @(negedge clk);
    end
    chk(!dav_a && !oe_a, "R10 done during block ignored", {dav_a, oe_a}, 0);
    chk(exp_q.size() == 0, "R10 no extra words", exp_q.size(), 0);
    repeat (3) @(negedge clk);

    // Two chained engines, B's permission is the inverse of A's dav.
    overlaps = 0;
    gaps = 0;
    push_block(16'hA000);
    push_block(16'hB000);
    pulse_done(1'b0);
    auto_on = 1'b1;
    while (!dav_a) @(negedge clk);
    pulse_done(1'b1);
    while (!dav_b) @(negedge clk);
    while (dav_b) @(negedge clk);
    auto_on = 1'b0;
    repeat (3) @(negedge clk);
    chk(overlaps == 0, "R11 no bus overlap", overlaps, 0);
    chk(gaps == 0, "R11 back-to-back blocks", gaps, 0);
    chk(exp_q.size() == 0, "R11 both blocks delivered", exp_q.size(), 0);
    chk(oe_mismatch == 0, "R7 bus_oe tracks dav", oe_mismatch, 0);

    summary();
    $finish;
  end

endmodule